// File: doc/BRIEF.md
# GPIO interrupt cause and mask unit

This block turns a vector of polarity-adjusted GPIO input levels into grouped interrupt requests. It watches the input vector every clock and, when a bit goes from 0 to 1, records that bit in an edge cause register. Each interrupt destination has its own edge cause register, edge mask and level mask. Its pending vector is the inputs selected by its level mask, ORed with the recorded edges selected by its edge mask. The pending vector is cut into groups of eight lines, and each group is ORed into one registered summary request.

There is one global destination and one destination per CPU, with up to four CPUs. The global registers sit in one register window and the per-CPU registers sit in a second window. Software arms lines through the masks. It acknowledges edges by writing the cause register: every bit written as 0 is cleared and every bit written as 1 is left alone. The choice between rising and falling detection is made upstream by the polarity applied to the input vector.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset every cause and mask register of every destination reads 0 and every summary output is low.
- R2: An input bit seen at 0 on one clock edge and at 1 on the next sets that bit in the edge cause register of every destination. An input that is already high when reset is released, or that stays high, sets nothing.
- R3: An edge cause bit stays set whatever the masks hold, and whatever the input does afterwards, until software clears it.
- R4: Writing a cause register clears each bit written as 0 and leaves each bit written as 1 unchanged. A new edge on a bit in the same cycle as a clearing write to that bit leaves the bit set.
- R5: The level part of the pending vector is the current input ANDed with the level mask. It is not latched, so it drops as soon as the input drops.
- R6: The pending vector is (input AND level mask) OR (edge cause AND edge mask). With both masks at 0, a destination raises no request.
- R7: Pending bits 8g to 8g+7 drive summary line g of that destination, with g from 0 to 3.
- R8: Summary outputs are registered. A level input shows on the summary one clock edge after it is sampled. An edge shows two clock edges after it is sampled: one edge to latch the cause and one to register the summary.
- R9: Global window (window select 0) layout: edge cause at offset 0x14, edge mask at 0x18, level mask at 0x1C. A write to any other offset changes nothing, and a read of any other offset returns 0.
- R10: Per-CPU window (window select 1) layout for CPU n: edge cause at n*4, edge mask at 0x10+n*4, level mask at 0x20+n*4. CPU n's registers drive only irq_cpu bits 4n to 4n+3, and the global registers drive only irq_glb. Offsets that belong to a CPU index of NCPU or above are ignored and read 0.
- R11: Clearing the edge cause of one destination leaves the edge causes of all other destinations unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lvl_in | input | LINES | Polarity-adjusted input levels |
| wr_en | input | 1 | Register write strobe |
| wr_win | input | 1 | Write window: 0 selects global, 1 selects per-CPU |
| wr_addr | input | 6 | Write byte offset |
| wr_data | input | LINES | Write data |
| rd_win | input | 1 | Read window: 0 selects global, 1 selects per-CPU |
| rd_addr | input | 6 | Read byte offset |
| rd_data | output | LINES | Combinational read data |
| irq_glb | output | LINES/GROUP | Summary requests of the global destination |
| irq_cpu | output | NCPU*LINES/GROUP | Summary requests of the CPUs, four lines per CPU |

## Verification
The main instance uses the default build: 32 lines, groups of eight and four CPUs. This makes every per-CPU offset live, and it lets every group land on every destination. A second instance built with two CPUs receives the same writes. Its reads and summaries show that offsets for CPU 2 and CPU 3 fall through without effect. Between them the two builds cover both a full per-CPU window and a partly populated one.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
   localparam int unsigned ADDR_W = 6;

   localparam logic [ADDR_W-1:0] GLB_CAUSE_OFF = 6'h14;
   localparam logic [ADDR_W-1:0] GLB_EMASK_OFF = 6'h18;
   localparam logic [ADDR_W-1:0] GLB_LMASK_OFF = 6'h1C;

   localparam logic [ADDR_W-1:0] CPU_CAUSE_BASE = 6'h00;
   localparam logic [ADDR_W-1:0] CPU_EMASK_BASE = 6'h10;
   localparam logic [ADDR_W-1:0] CPU_LMASK_BASE = 6'h20;
   localparam int unsigned       CPU_STRIDE     = 4;
   localparam int unsigned       MAX_CPU        = 4;

   // Register kinds held by every destination
   typedef enum logic [1:0] {
      KIND_NONE,
      KIND_CAUSE,
      KIND_EMASK,
      KIND_LMASK
   } reg_kind_e;

   function automatic logic [ADDR_W-1:0] cpu_off(input logic [ADDR_W-1:0] base,
                                                 input int unsigned       idx);
      return base + ADDR_W'(idx * CPU_STRIDE);
   endfunction
endpackage

// File: rtl/gpio_irq_edge.sv
module gpio_irq_edge #(
   parameter int unsigned LINES = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] lvl_in,
   output logic [LINES-1:0] rise
);
   logic [LINES-1:0] prev_q;
   logic             primed_q;

   // No edge can be reported until one valid sample has been taken
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q   <= '0;
         primed_q <= 1'b0;
      end else begin
         prev_q   <= lvl_in;
         primed_q <= 1'b1;
      end
   end

   assign rise = primed_q ? (lvl_in & ~prev_q) : '0;

   // R2: a reported edge needs the bit low on the previous clock edge
   a_r2_rise_from_low: assert property (@(posedge clk) disable iff (!rst_n)
      (rise & $past(lvl_in)) == '0);
endmodule

// File: rtl/gpio_irq_decode.sv
module gpio_irq_decode
   import gpio_irq_pkg::*;
#(
   parameter int unsigned NCPU = 4
) (
   input  logic              win,
   input  logic [ADDR_W-1:0] addr,
   output logic [NCPU:0]     hit_cause,
   output logic [NCPU:0]     hit_emask,
   output logic [NCPU:0]     hit_lmask
);
   reg_kind_e glb_kind;

   always_comb begin
      unique case (addr)
         GLB_CAUSE_OFF: glb_kind = KIND_CAUSE;
         GLB_EMASK_OFF: glb_kind = KIND_EMASK;
         GLB_LMASK_OFF: glb_kind = KIND_LMASK;
         default:       glb_kind = KIND_NONE;
      endcase
   end

   // Destination 0 is global; destination n+1 is CPU n
   always_comb begin
      hit_cause = '0;
      hit_emask = '0;
      hit_lmask = '0;
      if (!win) begin
         hit_cause[0] = (glb_kind == KIND_CAUSE);
         hit_emask[0] = (glb_kind == KIND_EMASK);
         hit_lmask[0] = (glb_kind == KIND_LMASK);
      end else begin
         for (int n = 0; n < NCPU; n++) begin
            hit_cause[n+1] = (addr == cpu_off(CPU_CAUSE_BASE, n));
            hit_emask[n+1] = (addr == cpu_off(CPU_EMASK_BASE, n));
            hit_lmask[n+1] = (addr == cpu_off(CPU_LMASK_BASE, n));
         end
      end
   end
endmodule

// File: rtl/gpio_irq_dest.sv
module gpio_irq_dest #(
   parameter int unsigned LINES = 32,
   parameter int unsigned GROUP = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [LINES-1:0]       lvl_in,
   input  logic [LINES-1:0]       rise,
   input  logic [LINES-1:0]       wr_data,
   input  logic                   we_cause,
   input  logic                   we_emask,
   input  logic                   we_lmask,
   output logic [LINES-1:0]       cause_o,
   output logic [LINES-1:0]       emask_o,
   output logic [LINES-1:0]       lmask_o,
   output logic [LINES/GROUP-1:0] irq_o
);
   localparam int unsigned NGRP = LINES / GROUP;

   logic [LINES-1:0] cause_q, emask_q, lmask_q;
   logic [LINES-1:0] cause_nxt, keep, pending;
   logic [NGRP-1:0]  grp_any, irq_q;

   // Zero-written bits drop; a fresh edge in the same cycle wins
   assign keep      = we_cause ? wr_data : '1;
   assign cause_nxt = (cause_q & keep) | rise;
   assign pending   = (lvl_in & lmask_q) | (cause_q & emask_q);

   for (genvar g = 0; g < NGRP; g++) begin : g_grp
      assign grp_any[g] = |pending[g*GROUP +: GROUP];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cause_q <= '0;
         emask_q <= '0;
         lmask_q <= '0;
         irq_q   <= '0;
      end else begin
         cause_q <= cause_nxt;
         if (we_emask) emask_q <= wr_data;
         if (we_lmask) lmask_q <= wr_data;
         irq_q <= grp_any;
      end
   end

   assign cause_o = cause_q;
   assign emask_o = emask_q;
   assign lmask_o = lmask_q;
   assign irq_o   = irq_q;

   // R2: every reported edge is recorded on the next cycle
   a_r2_edge_latched: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((cause_q & $past(rise)) == $past(rise)));
   // R3: without a cause write no bit ever drops
   a_r3_cause_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !we_cause |=> (($past(cause_q) & ~cause_q) == '0));
   // R4: bits written 0 with no new edge are cleared
   a_r4_zero_clears: assert property (@(posedge clk) disable iff (!rst_n)
      we_cause |=> ((cause_q & ~$past(wr_data) & ~$past(rise)) == '0));
   // R4: bits written 1 keep their value
   a_r4_one_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      we_cause |=> (($past(cause_q) & $past(wr_data) & ~cause_q) == '0));
   // R6: with both masks closed the destination stays quiet
   a_r6_masked_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (emask_q == '0 && lmask_q == '0) |=> (irq_q == '0));
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
   import gpio_irq_pkg::*;
#(
   parameter int unsigned LINES = 32,
   parameter int unsigned GROUP = 8,
   parameter int unsigned NCPU  = 4
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [LINES-1:0]            lvl_in,
   input  logic                        wr_en,
   input  logic                        wr_win,
   input  logic [ADDR_W-1:0]           wr_addr,
   input  logic [LINES-1:0]            wr_data,
   input  logic                        rd_win,
   input  logic [ADDR_W-1:0]           rd_addr,
   output logic [LINES-1:0]            rd_data,
   output logic [LINES/GROUP-1:0]      irq_glb,
   output logic [NCPU*LINES/GROUP-1:0] irq_cpu
);
   localparam int unsigned NGRP  = LINES / GROUP;
   localparam int unsigned NDEST = NCPU + 1;

   if (NCPU < 1 || NCPU > MAX_CPU) begin : g_bad_ncpu
      $error("NCPU must lie between 1 and %0d", MAX_CPU);
   end
   if (LINES < 1 || LINES > 32) begin : g_bad_lines
      $error("LINES must lie between 1 and 32");
   end
   if (GROUP < 1 || (LINES % GROUP) != 0) begin : g_bad_group
      $error("LINES must be a multiple of GROUP");
   end

   logic [LINES-1:0] rise;
   logic [NCPU:0]    wh_cause, wh_emask, wh_lmask;
   logic [NCPU:0]    rh_cause, rh_emask, rh_lmask;
   logic [LINES-1:0] cause_a [NDEST];
   logic [LINES-1:0] emask_a [NDEST];
   logic [LINES-1:0] lmask_a [NDEST];
   logic [NGRP-1:0]  irq_a   [NDEST];

   gpio_irq_edge #(.LINES(LINES)) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl_in (lvl_in),
      .rise   (rise)
   );

   gpio_irq_decode #(.NCPU(NCPU)) u_wdec (
      .win       (wr_win),
      .addr      (wr_addr),
      .hit_cause (wh_cause),
      .hit_emask (wh_emask),
      .hit_lmask (wh_lmask)
   );

   gpio_irq_decode #(.NCPU(NCPU)) u_rdec (
      .win       (rd_win),
      .addr      (rd_addr),
      .hit_cause (rh_cause),
      .hit_emask (rh_emask),
      .hit_lmask (rh_lmask)
   );

   for (genvar d = 0; d < NDEST; d++) begin : g_dest
      gpio_irq_dest #(.LINES(LINES), .GROUP(GROUP)) u_dest (
         .clk      (clk),
         .rst_n    (rst_n),
         .lvl_in   (lvl_in),
         .rise     (rise),
         .wr_data  (wr_data),
         .we_cause (wr_en & wh_cause[d]),
         .we_emask (wr_en & wh_emask[d]),
         .we_lmask (wr_en & wh_lmask[d]),
         .cause_o  (cause_a[d]),
         .emask_o  (emask_a[d]),
         .lmask_o  (lmask_a[d]),
         .irq_o    (irq_a[d])
      );
   end

   assign irq_glb = irq_a[0];
   for (genvar n = 0; n < NCPU; n++) begin : g_cpu_out
      assign irq_cpu[n*NGRP +: NGRP] = irq_a[n+1];
   end

   // One-hot AND-OR read mux; a miss returns zero
   always_comb begin
      rd_data = '0;
      for (int d = 0; d < NDEST; d++) begin
         rd_data |= ({LINES{rh_cause[d]}} & cause_a[d])
                  | ({LINES{rh_emask[d]}} & emask_a[d])
                  | ({LINES{rh_lmask[d]}} & lmask_a[d]);
      end
   end
endmodule

// File: tb/gpio_irq_unit_test.sv
module gpio_irq_unit_test;
   localparam int CLK_T = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] lvl_in = '0;
   logic        wr_en = 1'b0;
   logic        wr_win = 1'b0;
   logic [5:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        rd_win = 1'b0;
   logic [5:0]  rd_addr = '0;
   logic [31:0] rd_data, rd_data2;
   logic [3:0]  irq_glb, irq_glb2;
   logic [15:0] irq_cpu;
   logic [7:0]  irq_cpu2;
   int n_tests = 0;
   int n_fail  = 0;

   always #(CLK_T/2) clk = ~clk;

   gpio_irq_unit uut (
      .clk(clk), .rst_n(rst_n), .lvl_in(lvl_in), .wr_en(wr_en), .wr_win(wr_win),
      .wr_addr(wr_addr), .wr_data(wr_data), .rd_win(rd_win), .rd_addr(rd_addr),
      .rd_data(rd_data), .irq_glb(irq_glb), .irq_cpu(irq_cpu));

   gpio_irq_unit #(.NCPU(2)) uut_two (
      .clk(clk), .rst_n(rst_n), .lvl_in(lvl_in), .wr_en(wr_en), .wr_win(wr_win),
      .wr_addr(wr_addr), .wr_data(wr_data), .rd_win(rd_win), .rd_addr(rd_addr),
      .rd_data(rd_data2), .irq_glb(irq_glb2), .irq_cpu(irq_cpu2));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic win, input logic [5:0] addr, input logic [31:0] data);
      @(negedge clk);
      wr_en = 1'b1; wr_win = win; wr_addr = addr; wr_data = data;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic win, input logic [5:0] addr, output logic [31:0] data);
      rd_win = win; rd_addr = addr;
      #1 data = rd_data;
   endtask

   task automatic set_in(input logic [31:0] v);
      @(negedge clk);
      lvl_in = v;
   endtask

   task automatic wipe();
      set_in('0);
      wr(1'b0, 6'h14, '0); wr(1'b0, 6'h18, '0); wr(1'b0, 6'h1C, '0);
      for (int n = 0; n < 4; n++) begin
         wr(1'b1, 6'(n*4), '0);
         wr(1'b1, 6'(16 + n*4), '0);
         wr(1'b1, 6'(32 + n*4), '0);
      end
      tick(2);
   endtask

   task automatic t_reset();
      logic [31:0] v;
      lvl_in = 32'h0000_0100;
      tick(3);
      rst_n = 1'b1;
      tick(3);
      chk("R1 irq_glb after reset", 32'(irq_glb), 32'h0);
      chk("R1 irq_cpu after reset", 32'(irq_cpu), 32'h0);
      rd(1'b0, 6'h18, v); chk("R1 global edge mask", v, 32'h0);
      rd(1'b0, 6'h1C, v); chk("R1 global level mask", v, 32'h0);
      rd(1'b0, 6'h14, v); chk("R2 no edge from input high at release", v, 32'h0);
      rd(1'b1, 6'h0C, v); chk("R2 cpu3 cause after release", v, 32'h0);
   endtask

   task automatic t_edge();
      logic [31:0] v;
      wipe();
      wr(1'b0, 6'h18, 32'hFFFF_FFFF);
      set_in(32'h0000_0200);
      tick(1); chk("R8 edge not yet on summary", 32'(irq_glb), 32'h0);
      tick(1); chk("R7 bit9 on group1", 32'(irq_glb), 32'h2);
      rd(1'b0, 6'h14, v); chk("R2 global cause latched", v, 32'h200);
      rd(1'b1, 6'h00, v); chk("R2 cpu0 cause latched", v, 32'h200);
      chk("R10 cpu summaries masked", 32'(irq_cpu), 32'h0);
      set_in('0); tick(2);
      rd(1'b0, 6'h14, v); chk("R3 cause kept after input drop", v, 32'h200);
      chk("R3 summary kept", 32'(irq_glb), 32'h2);
      set_in(32'h0000_0200); tick(2);
      wr(1'b0, 6'h14, '0); tick(2);
      rd(1'b0, 6'h14, v); chk("R2 steady high gives no new edge", v, 32'h0);
      chk("R2 summary clear after ack", 32'(irq_glb), 32'h0);
   endtask

   task automatic t_clear();
      logic [31:0] v;
      wipe();
      wr(1'b0, 6'h18, 32'hFFFF_FFFF);
      set_in(32'h0000_0101); tick(2);
      wr(1'b0, 6'h14, 32'hFFFF_FFFE);
      rd(1'b0, 6'h14, v); chk("R4 zero clears, one keeps", v, 32'h100);
      tick(2); chk("R4 summary after partial ack", 32'(irq_glb), 32'h2);
      @(negedge clk);
      lvl_in = 32'h0000_0111;
      wr_en = 1'b1; wr_win = 1'b0; wr_addr = 6'h14; wr_data = '0;
      @(negedge clk);
      wr_en = 1'b0;
      rd(1'b0, 6'h14, v); chk("R4 edge wins over clear", v, 32'h10);
   endtask

   task automatic t_level();
      logic [31:0] v;
      wipe();
      wr(1'b0, 6'h1C, 32'h0010_0000);
      set_in(32'h0010_0000);
      tick(1); chk("R8 level one edge later", 32'(irq_glb), 32'h4);
      rd(1'b0, 6'h14, v); chk("R3 cause set though edge masked", v, 32'h0010_0000);
      set_in('0);
      tick(1); chk("R5 level not latched", 32'(irq_glb), 32'h0);
   endtask

   task automatic t_mask();
      logic [31:0] v;
      wipe();
      set_in(32'h8000_0000); tick(2);
      chk("R6 masked edge silent", 32'(irq_glb), 32'h0);
      rd(1'b0, 6'h14, v); chk("R3 masked edge recorded", v, 32'h8000_0000);
      wr(1'b0, 6'h18, 32'h8000_0000);
      tick(1); chk("R6 unmask raises group3", 32'(irq_glb), 32'h8);
      wr(1'b0, 6'h18, '0);
      tick(1); chk("R6 mask drops request", 32'(irq_glb), 32'h0);
   endtask

   task automatic t_percpu();
      logic [31:0] v;
      wipe();
      wr(1'b1, 6'h18, 32'hFF00_0000);
      set_in(32'h4000_0000); tick(2);
      chk("R10 cpu2 group3 only", 32'(irq_cpu), 32'h0800);
      chk("R10 global untouched", 32'(irq_glb), 32'h0);
      wr(1'b1, 6'h08, '0);
      tick(1); chk("R11 cpu2 ack drops its line", 32'(irq_cpu), 32'h0);
      rd(1'b1, 6'h04, v); chk("R11 cpu1 cause kept", v, 32'h4000_0000);
      rd(1'b0, 6'h14, v); chk("R11 global cause kept", v, 32'h4000_0000);
      wr(1'b1, 6'h20, 32'h1);
      set_in(32'h4000_0001);
      tick(1); chk("R10 cpu0 level on group0", 32'(irq_cpu), 32'h0001);
   endtask

   task automatic t_offsets();
      logic [31:0] v;
      wipe();
      wr(1'b0, 6'h00, 32'hFFFF_FFFF);
      wr(1'b0, 6'h10, 32'hFFFF_FFFF);
      rd(1'b0, 6'h00, v); chk("R9 unused offset reads zero", v, 32'h0);
      rd(1'b0, 6'h18, v); chk("R9 stray write left edge mask", v, 32'h0);
      wr(1'b0, 6'h1C, 32'hA5A5_A5A5);
      rd(1'b0, 6'h1C, v); chk("R9 level mask at 0x1C", v, 32'hA5A5_A5A5);
      wr(1'b1, 6'h1C, 32'h1234_5678);
      rd(1'b1, 6'h1C, v); chk("R10 cpu3 edge mask at 0x1C", v, 32'h1234_5678);
      chk("R10 absent cpu3 reads zero", rd_data2, 32'h0);
      set_in(32'h0000_0008); tick(2);
      chk("R10 absent cpu3 gives no request", 32'(irq_cpu2), 32'h0);
   endtask

   initial begin
      #(CLK_T * 100000);
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      t_reset();
      t_edge();
      t_clear();
      t_level();
      t_mask();
      t_percpu();
      t_offsets();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule